// File: doc/BRIEF.md
# Clock Time Seven-Segment Decoder Bank

This block turns the six BCD digit fields of a 24-hour time of day (hours, minutes, seconds, each as a tens and a units field) into six seven-segment patterns. It is used between a time-of-day counter and six digit displays. Each display position gets its own decoder, and each decoder is sized to the range of its own field. The hours-tens field is 2 bits wide. The minutes-tens and seconds-tens fields are 3 bits wide. The three units fields are 4 bits wide.

The block is purely combinational. It holds no registers and has no clock or reset, so every output is a function of the current inputs only. A decoder that receives a code outside its legal range turns every segment of its digit off. It never shows a partial or odd glyph. The hours-tens decoder renders all four of its codes (0 to 3). This lets the same decoder serve a day-of-month tens position.

Top module: `hms_seg_bank`

## Requirements
- R1: The six decoders are independent. Changing one digit field changes only the segment output of that same position.
- R2: The block holds no state. Each segment output follows its input field with no clock, and the result is the same whatever inputs were applied before.
- R3: The hours-tens decoder (2-bit input) renders codes 0, 1, 2 and 3 as the digits 0, 1, 2 and 3. None of its codes blanks.
- R4: The minutes-tens and seconds-tens decoders (3-bit inputs) render codes 0 to 5 as the digits 0 to 5.
- R5: On a 3-bit tens input, codes 6 and 7 give an all-off output (7'h00).
- R6: The three units decoders (4-bit inputs) render codes 0 to 9 as the digits 0 to 9.
- R7: On a 4-bit units input, codes 10 to 15 give an all-off output (7'h00).
- R8: Segments are active-high and packed as {g,f,e,d,c,b,a}, with a in bit 0. The glyphs are:
  - 0 = 7'h3F
  - 1 = 7'h06
  - 2 = 7'h5B
  - 3 = 7'h4F
  - 4 = 7'h66
  - 5 = 7'h6D
  - 6 = 7'h7D
  - 7 = 7'h07
  - 8 = 7'h7F
  - 9 = 7'h6F
- R9: Every time from 00:00:00 to 23:59:59 shows on all six positions at the same time with the correct glyphs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hr_tens_i | input | 2 | Hours tens field |
| hr_ones_i | input | 4 | Hours units field |
| mn_tens_i | input | 3 | Minutes tens field |
| mn_ones_i | input | 4 | Minutes units field |
| sc_tens_i | input | 3 | Seconds tens field |
| sc_ones_i | input | 4 | Seconds units field |
| hr_tens_seg_o | output | 7 | Hours tens segments {g..a} |
| hr_ones_seg_o | output | 7 | Hours units segments {g..a} |
| mn_tens_seg_o | output | 7 | Minutes tens segments {g..a} |
| mn_ones_seg_o | output | 7 | Minutes units segments {g..a} |
| sc_tens_seg_o | output | 7 | Seconds tens segments {g..a} |
| sc_ones_seg_o | output | 7 | Seconds units segments {g..a} |

## Verification
A directed sweep drives every code of each decoder in turn while the other five fields hold random values. This separates the legal glyphs from the blanking codes, and it shows any cross-talk between positions. A walk through all 86,400 legal times checks that the six positions agree with each other across every digit combination a running clock produces. Random mixes of legal and illegal codes, applied back to back, show that no output depends on an earlier input. The bench also swaps fields between neighbouring positions, which exposes wiring to the wrong position.

// File: rtl/hms_seg_pkg.sv
package hms_seg_pkg;

    localparam int unsigned SEG_W = 7;

    // field widths and largest legal code per position
    localparam int unsigned HT_W   = 2;
    localparam int unsigned HT_MAX = 3;
    localparam int unsigned TN_W   = 3;
    localparam int unsigned TN_MAX = 5;
    localparam int unsigned UN_W   = 4;
    localparam int unsigned UN_MAX = 9;

    // widest field any position uses
    localparam int unsigned DIG_W  = UN_W;

    typedef logic [SEG_W-1:0] seg_t;   // {g,f,e,d,c,b,a}

    localparam seg_t SEG_OFF = '0;

    // glyph for a decimal digit; anything else is dark
    function automatic seg_t digit_glyph(input logic [DIG_W-1:0] dig);
        seg_t s;
        case (dig)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = SEG_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_glyph.sv
module seg_glyph
    import hms_seg_pkg::*;
(
    input  logic [DIG_W-1:0] dig_i,
    input  logic             show_i,
    output seg_t             seg_o
);

    typedef struct packed {
        seg_t seg;
    } glyph_st_t;

    glyph_st_t glyph_d;

    always_comb begin
        glyph_d.seg = SEG_OFF;
        if (show_i) begin
            glyph_d.seg = digit_glyph(dig_i);
        end
    end

    assign seg_o = glyph_d.seg;

endmodule

// File: rtl/code_range_chk.sv
module code_range_chk #(
    parameter int unsigned IN_W     = 4,
    parameter int unsigned MAX_CODE = 9
) (
    input  logic [IN_W-1:0] code_i,
    output logic            legal_o
);

    localparam int unsigned    CMP_W = IN_W + 1;
    localparam logic [IN_W:0]  LIMIT = CMP_W'(MAX_CODE);

    typedef struct packed {
        logic legal;
    } rng_st_t;

    rng_st_t rng_d;

    always_comb begin
        rng_d.legal = ({1'b0, code_i} <= LIMIT);
    end

    assign legal_o = rng_d.legal;

endmodule

// File: rtl/digit_seg_dec.sv
module digit_seg_dec
    import hms_seg_pkg::*;
#(
    parameter int unsigned IN_W     = 4,
    parameter int unsigned MAX_CODE = 9
) (
    input  logic [IN_W-1:0] code_i,
    output seg_t            seg_o
);

    localparam int unsigned PAD_W = DIG_W - IN_W;

    logic [DIG_W-1:0] dig_w;
    logic             legal_w;

    generate
        if (IN_W < DIG_W) begin : g_pad
            assign dig_w = {{PAD_W{1'b0}}, code_i};
        end else begin : g_full
            assign dig_w = code_i;
        end
    endgenerate

    code_range_chk #(
        .IN_W     (IN_W),
        .MAX_CODE (MAX_CODE)
    ) i_rng (
        .code_i  (code_i),
        .legal_o (legal_w)
    );

    seg_glyph i_glyph (
        .dig_i  (dig_w),
        .show_i (legal_w),
        .seg_o  (seg_o)
    );

endmodule

// File: rtl/hms_seg_bank.sv
module hms_seg_bank
    import hms_seg_pkg::*;
(
    input  logic [HT_W-1:0]  hr_tens_i,
    input  logic [UN_W-1:0]  hr_ones_i,
    input  logic [TN_W-1:0]  mn_tens_i,
    input  logic [UN_W-1:0]  mn_ones_i,
    input  logic [TN_W-1:0]  sc_tens_i,
    input  logic [UN_W-1:0]  sc_ones_i,
    output logic [SEG_W-1:0] hr_tens_seg_o,
    output logic [SEG_W-1:0] hr_ones_seg_o,
    output logic [SEG_W-1:0] mn_tens_seg_o,
    output logic [SEG_W-1:0] mn_ones_seg_o,
    output logic [SEG_W-1:0] sc_tens_seg_o,
    output logic [SEG_W-1:0] sc_ones_seg_o
);

    localparam int unsigned NPAIR = 2;   // minutes, seconds share a layout

    digit_seg_dec #(.IN_W(HT_W), .MAX_CODE(HT_MAX)) i_hr_tens (
        .code_i (hr_tens_i),
        .seg_o  (hr_tens_seg_o)
    );

    digit_seg_dec #(.IN_W(UN_W), .MAX_CODE(UN_MAX)) i_hr_ones (
        .code_i (hr_ones_i),
        .seg_o  (hr_ones_seg_o)
    );

    logic [NPAIR-1:0][TN_W-1:0]  pr_tens_w;
    logic [NPAIR-1:0][UN_W-1:0]  pr_ones_w;
    seg_t [NPAIR-1:0]            pr_tens_seg_w;
    seg_t [NPAIR-1:0]            pr_ones_seg_w;

    assign pr_tens_w = {sc_tens_i, mn_tens_i};
    assign pr_ones_w = {sc_ones_i, mn_ones_i};

    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            digit_seg_dec #(.IN_W(TN_W), .MAX_CODE(TN_MAX)) i_tens (
                .code_i (pr_tens_w[p]),
                .seg_o  (pr_tens_seg_w[p])
            );
            digit_seg_dec #(.IN_W(UN_W), .MAX_CODE(UN_MAX)) i_ones (
                .code_i (pr_ones_w[p]),
                .seg_o  (pr_ones_seg_w[p])
            );
        end
    endgenerate

    assign mn_tens_seg_o = pr_tens_seg_w[0];
    assign mn_ones_seg_o = pr_ones_seg_w[0];
    assign sc_tens_seg_o = pr_tens_seg_w[1];
    assign sc_ones_seg_o = pr_ones_seg_w[1];

endmodule

// File: rtl/hms_seg_bank_chk.sv
module hms_seg_bank_chk
    import hms_seg_pkg::*;
(
    input logic [HT_W-1:0]  hr_tens_i,
    input logic [UN_W-1:0]  hr_ones_i,
    input logic [TN_W-1:0]  mn_tens_i,
    input logic [UN_W-1:0]  mn_ones_i,
    input logic [TN_W-1:0]  sc_tens_i,
    input logic [UN_W-1:0]  sc_ones_i,
    input logic [SEG_W-1:0] hr_tens_seg_o,
    input logic [SEG_W-1:0] hr_ones_seg_o,
    input logic [SEG_W-1:0] mn_tens_seg_o,
    input logic [SEG_W-1:0] mn_ones_seg_o,
    input logic [SEG_W-1:0] sc_tens_seg_o,
    input logic [SEG_W-1:0] sc_ones_seg_o
);

    always_comb begin
        if (!$isunknown(hr_tens_i)) begin
            a_r3_hr_tens_lit: assert ($countones(hr_tens_seg_o) >= 2);
        end
        if (!$isunknown(mn_tens_i) && mn_tens_i > 3'd5) begin
            a_r5_mn_tens_blank: assert (mn_tens_seg_o == 7'h00);
        end
        if (!$isunknown(sc_tens_i) && sc_tens_i > 3'd5) begin
            a_r5_sc_tens_blank: assert (sc_tens_seg_o == 7'h00);
        end
        if (!$isunknown(hr_ones_i) && hr_ones_i > 4'd9) begin
            a_r7_hr_ones_blank: assert (hr_ones_seg_o == 7'h00);
        end
        if (!$isunknown(mn_ones_i) && mn_ones_i > 4'd9) begin
            a_r7_mn_ones_blank: assert (mn_ones_seg_o == 7'h00);
        end
        if (!$isunknown(sc_ones_i) && sc_ones_i > 4'd9) begin
            a_r7_sc_ones_blank: assert (sc_ones_seg_o == 7'h00);
        end
        if (!$isunknown(mn_tens_i) && mn_tens_i <= 3'd5) begin
            a_r4_mn_tens_lit: assert ($countones(mn_tens_seg_o) >= 2);
        end
        if (!$isunknown(sc_ones_i) && sc_ones_i <= 4'd9) begin
            a_r6_sc_ones_lit: assert ($countones(sc_ones_seg_o) >= 2);
        end
        if (!$isunknown(hr_ones_i) && hr_ones_i == 4'd8) begin
            a_r8_eight_full: assert (hr_ones_seg_o == 7'h7F);
        end
    end

endmodule

bind hms_seg_bank hms_seg_bank_chk i_chk (
    .hr_tens_i     (hr_tens_i),
    .hr_ones_i     (hr_ones_i),
    .mn_tens_i     (mn_tens_i),
    .mn_ones_i     (mn_ones_i),
    .sc_tens_i     (sc_tens_i),
    .sc_ones_i     (sc_ones_i),
    .hr_tens_seg_o (hr_tens_seg_o),
    .hr_ones_seg_o (hr_ones_seg_o),
    .mn_tens_seg_o (mn_tens_seg_o),
    .mn_ones_seg_o (mn_ones_seg_o),
    .sc_tens_seg_o (sc_tens_seg_o),
    .sc_ones_seg_o (sc_ones_seg_o)
);

// File: tb/test_hms_seg_bank.sv
module test_hms_seg_bank;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [1:0] hr_tens;
    logic [3:0] hr_ones, mn_ones, sc_ones;
    logic [2:0] mn_tens, sc_tens;
    logic [6:0] s_ht, s_ho, s_mt, s_mo, s_st, s_so;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    hms_seg_bank i_hms_seg_bank (
        .hr_tens_i     (hr_tens),
        .hr_ones_i     (hr_ones),
        .mn_tens_i     (mn_tens),
        .mn_ones_i     (mn_ones),
        .sc_tens_i     (sc_tens),
        .sc_ones_i     (sc_ones),
        .hr_tens_seg_o (s_ht),
        .hr_ones_seg_o (s_ho),
        .mn_tens_seg_o (s_mt),
        .mn_ones_seg_o (s_mo),
        .sc_tens_seg_o (s_st),
        .sc_ones_seg_o (s_so)
    );

    function automatic logic [6:0] exp_seg(input int v, input int lim);
        logic [6:0] g;
        if (v > lim) return 7'h00;
        case (v)
            0: g = 7'h3F;  1: g = 7'h06;  2: g = 7'h5B;  3: g = 7'h4F;
            4: g = 7'h66;  5: g = 7'h6D;  6: g = 7'h7D;  7: g = 7'h07;
            8: g = 7'h7F;  9: g = 7'h6F;  default: g = 7'h00;
        endcase
        return g;
    endfunction

    task automatic chk(input string req, input logic [6:0] got, input logic [6:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (in %0d %0d %0d %0d %0d %0d)",
                     req, got, exp, hr_tens, hr_ones, mn_tens, mn_ones, sc_tens, sc_ones);
        end
    endtask

    // all six positions against their own reference
    task automatic chk_all(input string req);
        chk(req, s_ht, exp_seg(int'(hr_tens), 3));
        chk(req, s_ho, exp_seg(int'(hr_ones), 9));
        chk(req, s_mt, exp_seg(int'(mn_tens), 5));
        chk(req, s_mo, exp_seg(int'(mn_ones), 9));
        chk(req, s_st, exp_seg(int'(sc_tens), 5));
        chk(req, s_so, exp_seg(int'(sc_ones), 9));
    endtask

    task automatic drive(input logic [1:0] ht, input logic [3:0] ho, input logic [2:0] mt,
                         input logic [3:0] mo, input logic [2:0] st, input logic [3:0] so);
        @(posedge clk);
        hr_tens = ht; hr_ones = ho; mn_tens = mt;
        mn_ones = mo; sc_tens = st; sc_ones = so;
        @(negedge clk);
    endtask

    task automatic drive_rand();
        drive(2'($urandom), 4'($urandom), 3'($urandom),
              4'($urandom), 3'($urandom), 4'($urandom));
    endtask

    initial begin
        logic [6:0] keep_ht, keep_ho, keep_mt, keep_mo, keep_st;
        int seed;
        seed = $urandom(32'h5EC7_0A11);
        hr_tens = '0; hr_ones = '0; mn_tens = '0;
        mn_ones = '0; sc_tens = '0; sc_ones = '0;
        @(negedge clk);
        // initial state: all fields zero shows 00:00:00
        chk("R8 zero", s_ht, 7'h3F);
        chk_all("R9 start");

        // R3: every hours-tens code, others random
        for (int c = 0; c < 4; c++) begin
            drive(2'(c), 4'($urandom), 3'($urandom), 4'($urandom), 3'($urandom), 4'($urandom));
            chk("R3", s_ht, exp_seg(c, 3));
            chk_all("R1 ht sweep");
        end
        // R4/R5: 3-bit tens positions, every code
        for (int c = 0; c < 8; c++) begin
            drive(2'($urandom), 4'($urandom), 3'(c), 4'($urandom), 3'(7 - c), 4'($urandom));
            chk(c > 5 ? "R5 mn" : "R4 mn", s_mt, exp_seg(c, 5));
            chk((7 - c) > 5 ? "R5 sc" : "R4 sc", s_st, exp_seg(7 - c, 5));
            chk_all("R1 tens sweep");
        end
        // R6/R7: 4-bit units positions, every code
        for (int c = 0; c < 16; c++) begin
            drive(2'($urandom), 4'(c), 3'($urandom), 4'((c + 5) % 16), 3'($urandom), 4'(15 - c));
            chk(c > 9 ? "R7 hr" : "R6 hr", s_ho, exp_seg(c, 9));
            chk(((c + 5) % 16) > 9 ? "R7 mn" : "R6 mn", s_mo, exp_seg((c + 5) % 16, 9));
            chk((15 - c) > 9 ? "R7 sc" : "R6 sc", s_so, exp_seg(15 - c, 9));
        end
        // R8 explicit glyph table on seconds-units
        for (int c = 0; c < 10; c++) begin
            drive(2'd0, 4'd0, 3'd0, 4'd0, 3'd0, 4'(c));
            chk("R8 glyph", s_so, exp_seg(c, 9));
        end
        // R1: move only seconds-units, other outputs must not change
        drive(2'd2, 4'd3, 3'd4, 4'd7, 3'd1, 4'd0);
        keep_ht = s_ht; keep_ho = s_ho; keep_mt = s_mt; keep_mo = s_mo; keep_st = s_st;
        for (int c = 1; c < 16; c++) begin
            drive(2'd2, 4'd3, 3'd4, 4'd7, 3'd1, 4'(c));
            chk("R1 iso ht", s_ht, keep_ht);
            chk("R1 iso ho", s_ho, keep_ho);
            chk("R1 iso mt", s_mt, keep_mt);
            chk("R1 iso mo", s_mo, keep_mo);
            chk("R1 iso st", s_st, keep_st);
        end
        // R2: random codes, outputs depend only on present inputs
        for (int k = 0; k < 400; k++) begin
            drive_rand();
            chk_all("R2 random");
        end
        // R2: same input after different histories
        drive(2'd3, 4'd15, 3'd7, 4'd10, 3'd6, 4'd12);
        drive(2'd1, 4'd4, 3'd2, 4'd9, 3'd5, 4'd1);
        chk_all("R2 after blank");
        drive(2'd1, 4'd8, 3'd0, 4'd8, 3'd0, 4'd8);
        drive(2'd1, 4'd4, 3'd2, 4'd9, 3'd5, 4'd1);
        chk_all("R2 after full");
        // R9: every legal time of day
        for (int h = 0; h < 24; h++) begin
            for (int m = 0; m < 60; m++) begin
                for (int s = 0; s < 60; s++) begin
                    drive(2'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10), 3'(s / 10), 4'(s % 10));
                    chk_all("R9 time");
                end
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule